// File: doc/BRIEF.md
# Frame-Rate-Control Colour Dither Unit

This unit turns one packed pixel per cycle into on/off drive bits for a passive panel's three sub-pixels. A pixel carries red, green and blue intensity fields; each field picks a 4-bit duty-cycle code from a small programmable table, and that code picks a temporal on/off pattern. The unit steps through the pattern by counting frames, so over several frames each sub-pixel is lit for a fixed fraction of the time. In greyscale mode only the two low pixel bits are used: they go through the blue table, and the result drives a single output bit.

The sixteen duty-cycle codes cover fractions with denominators 3, 4, 5 and 7, plus constant on and constant off. Each pair of complementary fractions shares one stored pattern. The larger fraction uses the pattern as written and the smaller one uses its bitwise inverse. All tables and patterns go through a write port into shadow copies. The copies in use are refreshed only at a frame start, so a frame is never drawn with a mix of old and new settings.

Top module: `frc_dither`

## Requirements
- R1: `pix_i` is split into red = bits 7:5, green = bits 4:2 and blue = bits 1:0. These drive `sub_o[2]`, `sub_o[1]` and `sub_o[0]` respectively. The output is combinational from `pix_i` and the state in use.
- R2: The red table is at address 0 and the green table at address 1. Entry n of each is the 4-bit code in bits 4n+3:4n. Both reset to 0x02468ACF, which gives codes 15, 12, 10, 8, 6, 4, 2, 0 for entries 0 through 7.
- R3: The blue table is at address 2. Entry n is in bits 4n+3:4n for n = 0..3, and the table resets to 0x000004BF.
- R4: Code 0 drives the bit always on and code 15 drives it always off.
- R5: Codes 1 through 8 are 6/7, 4/5, 3/4, 5/7, 2/3, 3/5, 4/7 and 2/4. Each outputs bit p of its stored pattern, where p is the frame phase for its denominator. Codes 9 through 14 are 3/7, 2/5, 1/3, 2/7, 1/5 and 1/7. Each outputs the inverse of that bit from the pattern of its complement.
- R6: The pattern addresses are: 3 for 2/3, 4 for quarters, 5 for 4/5, 6 for 3/5, 7 for 6/7, 8 for 5/7 and 9 for 4/7. Address 4 holds 2/4 in bits 3:0 and 3/4 in bits 19:16. Writes to addresses 10 to 15 have no effect.
- R7: Four phase counters reset to 0. Each advances by one on every frame start and wraps after 3, 4, 5 and 7 frames respectively.
- R8: A write goes to a shadow copy and has no effect on `sub_o` until the next frame start. A write made in the same cycle as a frame start waits for the frame start after that one.
- R9: When `grey_i` is high, `sub_o[0]` follows the blue table indexed by `pix_i[1:0]`, and `sub_o[2:1]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| frame_start_i | input | 1 | one-cycle strobe marking the start of a frame |
| wr_en_i | input | 1 | register write enable |
| wr_addr_i | input | 4 | register address |
| wr_data_i | input | 32 | register write data |
| grey_i | input | 1 | 2-bit greyscale mode |
| pix_i | input | 8 | pixel value |
| sub_o | output | 3 | sub-pixel drive bits {red, green, blue} |

## Verification
A register write and a frame start can fall in the same cycle, and a frame start always coincides with a phase counter step or wrap. The bench provokes the first case directly, by writing a table at the same edge as a frame strobe. It also produces both cases at random, with writes and strobes each arriving at random. The result is judged against a bench model, in which the shadow copy is promoted before the same-cycle write is applied. Output bits are checked every cycle, including cycles where a counter wraps.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 10;
  localparam int NUM_PER  = 4;
  localparam int PH_W     = 3;
  localparam int CODE_W   = 4;

  localparam logic [ADDR_W-1:0] A_RED = 4'd0, A_GRN = 4'd1, A_BLU = 4'd2,
    A_P23 = 4'd3, A_P4X = 4'd4, A_P45 = 4'd5, A_P35 = 4'd6,
    A_P67 = 4'd7, A_P57 = 4'd8, A_P47 = 4'd9;

  // phase counter slots
  localparam int PI3 = 0, PI4 = 1, PI5 = 2, PI7 = 3;

  typedef enum logic [CODE_W-1:0] {
    D_ONE = 4'd0, D_6_7, D_4_5, D_3_4, D_5_7, D_2_3, D_3_5, D_4_7,
    D_2_4, D_3_7, D_2_5, D_1_3, D_2_7, D_1_5, D_1_7, D_ZERO
  } duty_e;

  function automatic int period_of(int idx);
    case (idx)
      PI3: return 3;
      PI4: return 4;
      PI5: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_val(int a);
    case (a)
      0, 1: return 32'h0246_8ACF;
      2: return 32'h0000_04BF;
      3: return 32'h0000_0003;
      4: return 32'h0007_0005;
      5: return 32'h0000_000F;
      6: return 32'h0000_0015;
      7: return 32'h0000_003F;
      8: return 32'h0000_005B;
      default: return 32'h0000_0055;
    endcase
  endfunction
endpackage

// File: rtl/frc_reg_bank.sv
module frc_reg_bank
  import frc_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               frame_start_i,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    active_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] shadow_q, active_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[r] <= reset_val(r);
        active_q[r] <= reset_val(r);
      end else begin
        if (frame_start_i) active_q[r] <= shadow_q[r];
        if (wr_en_i && wr_addr_i == ADDR_W'(r)) shadow_q[r] <= wr_data_i;
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/frc_phase_gen.sv
module frc_phase_gen
  import frc_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_start_i,
  output logic [NUM_PER-1:0][PH_W-1:0]  phase_o
);
  for (genvar i = 0; i < NUM_PER; i++) begin : g_ph
    localparam logic [PH_W-1:0] LAST = PH_W'(period_of(i) - 1);
    logic [PH_W-1:0] ph_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            ph_q <= '0;
      else if (frame_start_i) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
    assign phase_o[i] = ph_q;
  end
endmodule

// File: rtl/frc_duty_sel.sv
module frc_duty_sel
  import frc_pkg::*;
(
  input  logic [CODE_W-1:0]                code_i,
  input  logic [NUM_PER-1:0][PH_W-1:0]     phase_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  output logic                             bit_o
);
  logic [PH_W-1:0] p3, p4, p5, p7;
  logic [DATA_W-1:0] r23, r4x, r45, r35, r67, r57, r47;

  assign p3 = phase_i[PI3];
  assign p4 = phase_i[PI4];
  assign p5 = phase_i[PI5];
  assign p7 = phase_i[PI7];
  assign r23 = regs_i[A_P23];
  assign r4x = regs_i[A_P4X];
  assign r45 = regs_i[A_P45];
  assign r35 = regs_i[A_P35];
  assign r67 = regs_i[A_P67];
  assign r57 = regs_i[A_P57];
  assign r47 = regs_i[A_P47];

  always_comb begin
    unique case (duty_e'(code_i))
      D_ONE:  bit_o = 1'b1;
      D_6_7:  bit_o = r67[p7];
      D_4_5:  bit_o = r45[p5];
      D_3_4:  bit_o = r4x[5'd16 + {2'b0, p4}];
      D_5_7:  bit_o = r57[p7];
      D_2_3:  bit_o = r23[p3];
      D_3_5:  bit_o = r35[p5];
      D_4_7:  bit_o = r47[p7];
      D_2_4:  bit_o = r4x[p4];
      // smaller fraction of a pair: inverse of the shared pattern
      D_3_7:  bit_o = ~r47[p7];
      D_2_5:  bit_o = ~r35[p5];
      D_1_3:  bit_o = ~r23[p3];
      D_2_7:  bit_o = ~r57[p7];
      D_1_5:  bit_o = ~r45[p5];
      D_1_7:  bit_o = ~r67[p7];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
  import frc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              grey_i,
  input  logic [7:0]        pix_i,
  output logic [2:0]        sub_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_w;
  logic [NUM_PER-1:0][PH_W-1:0]    phase_w;
  logic [2:0][CODE_W-1:0]          code_w;
  logic [2:0]                      raw_w;

  frc_reg_bank i_regs (
    .clk_i, .rst_ni, .frame_start_i, .wr_en_i,
    .wr_addr_i, .wr_data_i, .active_o(regs_w)
  );

  frc_phase_gen i_phase (
    .clk_i, .rst_ni, .frame_start_i, .phase_o(phase_w)
  );

  assign code_w[2] = regs_w[A_RED][{pix_i[7:5], 2'b00} +: CODE_W];
  assign code_w[1] = regs_w[A_GRN][{pix_i[4:2], 2'b00} +: CODE_W];
  assign code_w[0] = regs_w[A_BLU][{1'b0, pix_i[1:0], 2'b00} +: CODE_W];

  for (genvar c = 0; c < 3; c++) begin : g_ch
    frc_duty_sel i_sel (
      .code_i(code_w[c]), .phase_i(phase_w), .regs_i(regs_w), .bit_o(raw_w[c])
    );
  end

  assign sub_o = grey_i ? {2'b00, raw_w[0]} : raw_w;
endmodule

// File: rtl/frc_dither_chk.sv
module frc_dither_chk
  import frc_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          frame_start_i,
  input logic                          grey_i,
  input logic [7:0]                    pix_i,
  input logic [2:0]                    sub_o,
  input logic [NUM_PER-1:0][PH_W-1:0]  phase_w
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;

  assert_grey_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grey_i |-> sub_o[2:1] == 2'b00);

  assert_phase_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_w[PI3] < 3'd3 && phase_w[PI4] < 3'd4 && phase_w[PI5] < 3'd5 && phase_w[PI7] < 3'd7);

  assert_phase7_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> phase_w[PI7] == ($past(phase_w[PI7]) == 3'd6 ? 3'd0 : $past(phase_w[PI7]) + 3'd1));

  assert_phase3_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> phase_w[PI3] == ($past(phase_w[PI3]) == 3'd2 ? 3'd0 : $past(phase_w[PI3]) + 3'd1));

  assert_phase_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(phase_w));

  assert_no_midframe_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(frame_start_i) && $stable(pix_i) && $stable(grey_i) |-> $stable(sub_o));
endmodule

bind frc_dither frc_dither_chk i_chk (
  .clk_i, .rst_ni, .frame_start_i, .grey_i, .pix_i, .sub_o, .phase_w
);

// File: tb/test_frc_dither.sv
module test_frc_dither;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic frame_start_i = 1'b0, wr_en_i = 1'b0, grey_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0] pix_i = '0;
  logic [2:0] sub_o;

  int n_checks = 0, n_fail = 0;
  logic [31:0] sh [10];
  logic [31:0] ac [10];
  int ph [4];

  frc_dither i_frc_dither (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] rst_val(int a);
    case (a)
      0, 1: return 32'h0246_8ACF;
      2: return 32'h0000_04BF;
      3: return 32'h3;  4: return 32'h0007_0005; 5: return 32'hF;
      6: return 32'h15; 7: return 32'h3F;        8: return 32'h5B;
      default: return 32'h55;
    endcase
  endfunction

  // R4 R5 R6: expected bit for a duty code
  function automatic logic exp_bit(logic [3:0] c);
    case (c)
      0: return 1'b1;
      1: return ac[7][ph[3]];
      2: return ac[5][ph[2]];
      3: return ac[4][16 + ph[1]];
      4: return ac[8][ph[3]];
      5: return ac[3][ph[0]];
      6: return ac[6][ph[2]];
      7: return ac[9][ph[3]];
      8: return ac[4][ph[1]];
      9: return !ac[9][ph[3]];
      10: return !ac[6][ph[2]];
      11: return !ac[3][ph[0]];
      12: return !ac[8][ph[3]];
      13: return !ac[5][ph[2]];
      14: return !ac[7][ph[3]];
      default: return 1'b0;
    endcase
  endfunction

  // R1 R2 R3 R9
  function automatic logic [2:0] exp_out(logic [7:0] p, logic g);
    logic r, gn, b;
    r  = exp_bit(ac[0][4*p[7:5] +: 4]);
    gn = exp_bit(ac[1][4*p[4:2] +: 4]);
    b  = exp_bit(ac[2][4*p[1:0] +: 4]);
    return g ? {2'b00, b} : {r, gn, b};
  endfunction

  task automatic check(string tag, logic [2:0] exp);
    n_checks++;
    if (sub_o !== exp) begin
      n_fail++;
      $display("FAIL %s pix=%02h grey=%0b got=%03b exp=%03b", tag, pix_i, grey_i, sub_o, exp);
    end
  endtask

  // drive one cycle, check before the edge, then advance the model
  task automatic cyc(logic fs, logic we, logic [3:0] a, logic [31:0] d,
                     logic [7:0] p, logic g, string tag);
    @(negedge clk_i);
    frame_start_i = fs; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    pix_i = p; grey_i = g;
    #1 check(tag, exp_out(p, g));
    @(posedge clk_i);
    if (fs) begin
      for (int i = 0; i < 10; i++) ac[i] = sh[i];
      ph[0] = (ph[0] + 1) % 3; ph[1] = (ph[1] + 1) % 4;
      ph[2] = (ph[2] + 1) % 5; ph[3] = (ph[3] + 1) % 7;
    end
    if (we && a < 10) sh[a] = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    for (int i = 0; i < 10; i++) begin sh[i] = rst_val(i); ac[i] = rst_val(i); end
    for (int i = 0; i < 4; i++) ph[i] = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // reset state, R2 R3 R4
    cyc(0, 0, 0, 0, 8'hFF, 0, "R4 reset all-on");
    check("R4 reset all-on literal", 3'b111);
    cyc(0, 0, 0, 0, 8'h00, 0, "R4 reset all-off");
    check("R4 reset all-off literal", 3'b000);
    cyc(0, 0, 0, 0, 8'h03, 1, "R9 grey on");
    check("R9 grey literal", 3'b001);
    cyc(0, 0, 0, 0, 8'hFC, 1, "R9 grey masks red/green");
    check("R9 grey mask literal", 3'b000);

    // R8: write without frame start has no effect
    cyc(0, 1, 4'd0, 32'h0, 8'h00, 0, "R8 write issued");
    cyc(0, 0, 0, 0, 8'h00, 0, "R8 before frame");
    check("R8 before frame literal", 3'b000);
    cyc(1, 0, 0, 0, 8'h00, 0, "R8 frame strobe");
    cyc(0, 0, 0, 0, 8'h00, 0, "R8 after frame");
    check("R8 after frame literal", 3'b100);
    // R8: write coinciding with frame start waits one more frame
    cyc(1, 1, 4'd0, 32'hFFFF_FFFF, 8'h00, 0, "R8 same-cycle");
    cyc(0, 0, 0, 0, 8'h00, 0, "R8 same-cycle held");
    check("R8 same-cycle held literal", 3'b100);
    cyc(1, 0, 0, 0, 8'h00, 0, "R8 next frame");
    cyc(0, 0, 0, 0, 8'h00, 0, "R8 applied");
    check("R8 applied literal", 3'b000);
    // R6: unmapped address ignored
    cyc(0, 1, 4'd12, 32'h0, 8'hFF, 0, "R6 unmapped write");
    cyc(1, 0, 0, 0, 8'hFF, 0, "R6 frame");
    cyc(0, 0, 0, 0, 8'h1C, 0, "R6 unmapped ignored");

    // R5 R7: each code on red across many frames
    for (int c = 0; c < 16; c++) begin
      cyc(0, 1, 4'd0, {8{c[3:0]}}, 8'hE0, 0, "R5 load code");
      for (int f = 0; f < 9; f++) begin
        cyc(1, 0, 0, 0, 8'hE0, 0, "R7 frame step");
        cyc(0, 0, 0, 0, 8'hE0, 0, "R5 code pattern");
      end
    end

    // random mix, R1 R2 R3 R5 R6 R7 R8 R9
    for (int k = 0; k < 4000; k++) begin
      logic fs, we, g;
      logic [3:0] a;
      fs = ($urandom % 5) == 0;
      we = ($urandom % 4) == 0;
      g  = ($urandom % 8) == 0;
      a  = 4'($urandom % 12);
      cyc(fs, we, a, $urandom, 8'($urandom), g, "R1 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule